// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns one operand specifier into the address a load or store will use. It takes a 4-bit mode code, the base and index register values already read from the register file, a 16-bit constant field and a 2-bit scale select. From these it produces the effective address. For the auto-modifying modes it also produces the new base-register value and a write enable. Register and immediate operands need no address, so they are reported through a no-memory flag.

Work is accepted through a valid/ready handshake. Every mode except memory indirect finishes with a single-cycle `done` pulse in the cycle after acceptance. Memory indirect issues a read on a synchronous memory port in the acceptance cycle. It then reports the returned word as the address one cycle later, and it holds off new work while the read is outstanding. The operation on the operand itself is left to the datapath that consumes these results.

Top module: `ea_unit`

## Requirements
- R1: During and right after reset, `done`, `wb_en` and `mem_req` are 0, `ea_out` is 0 and `in_ready` is 1.
- R2: Mode 2 (displacement) gives sign-extended `disp` plus `base_val`. Mode 3 (register indirect) gives `base_val`. Mode 4 (indexed) gives `base_val + index_val`. Each result appears with `done` high and `no_mem` low in the cycle after acceptance.
- R3: Mode 5 (absolute) gives `disp` sign-extended from bit 15 to the address width.
- R4: Mode 9 (scaled) gives sign-extended `disp + base_val + index_val * d`, where d = 1, 2, 4, 8 for `scale_sel` = 0, 1, 2, 3.
- R5: Mode 7 (autoincrement) gives `base_val` as the address, with `wb_en` high and `wb_val = base_val + d`.
- R6: Mode 8 (autodecrement) gives `base_val - d` both as the address and as `wb_val`, with `wb_en` high, wrapping modulo 2^32.
- R7: Mode 6 (memory indirect) raises `mem_req` with `mem_addr = base_val` in the acceptance cycle. In the next cycle `in_ready` and `done` are low. In the cycle after that, `done` is high and `ea_out` equals the word the memory returned.
- R8: Modes 0 (register), 1 (immediate) and the unused codes 10 to 15 give `no_mem` high, `ea_out` 0 and `wb_en` low, and raise no `mem_req`.
- R9: `done` is a one-cycle pulse per accepted operand. With no accepted input it stays low. Non-indirect operands may be accepted on every cycle.
- R10: `wb_en` is high only together with `done`, and only for modes 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand specifier valid |
| in_ready | output | 1 | Block can accept a specifier |
| mode | input | 4 | Addressing-mode code |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| disp | input | 16 | Constant / displacement field |
| scale_sel | input | 2 | Element size select, d = 1 << scale_sel |
| mem_req | output | 1 | Indirect pointer read request |
| mem_addr | output | 32 | Indirect pointer read address |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| done | output | 1 | Result valid pulse |
| no_mem | output | 1 | Operand needs no memory address |
| ea_out | output | 32 | Effective address |
| wb_en | output | 1 | Base register write-back enable |
| wb_val | output | 32 | New base register value |

## Verification
Direct modes register their result at the acceptance edge, so the bench drives inputs on the falling edge and reads `done`, `ea_out`, `no_mem`, `wb_en` and `wb_val` one falling edge later. For memory indirect, `mem_req` and `mem_addr` are combinational and are checked shortly after the inputs are driven. `in_ready` low and `done` low are checked one falling edge later. The final address is checked at the second falling edge, against a bench memory model that answers one edge after the request. Random operands are issued back to back without idle cycles, so each result is checked in the cycle before the next one replaces it.

// File: rtl/ea_pkg.sv
package ea_pkg;
   typedef enum logic [3:0] {
      M_REG  = 4'd0,
      M_IMM  = 4'd1,
      M_DISP = 4'd2,
      M_RIND = 4'd3,
      M_IDX  = 4'd4,
      M_ABS  = 4'd5,
      M_MIND = 4'd6,
      M_AINC = 4'd7,
      M_ADEC = 4'd8,
      M_SCL  = 4'd9
   } ea_mode_e;
endpackage

// File: rtl/ea_scale.sv
module ea_scale #(
   parameter int AW = 32,
   parameter int SW = 2
) (
   input  logic [AW-1:0] val,
   input  logic [SW-1:0] sel,
   output logic [AW-1:0] res
);
   localparam int NOPT = 1 << SW;

   logic [AW-1:0] opt [NOPT];

   for (genvar k = 0; k < NOPT; k++) begin : g_opt
      assign opt[k] = val << k;
   end

   assign res = opt[sel];
endmodule

// File: rtl/ea_calc.sv
module ea_calc
   import ea_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 16,
   parameter int SW         = 2,
   parameter bit ABS_SIGNED = 1'b1
) (
   input  logic [3:0]    mode,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] index,
   input  logic [DW-1:0] disp,
   input  logic [SW-1:0] sel,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] wb,
   output logic          wb_en,
   output logic          no_mem,
   output logic          indirect
);
   localparam int XW = AW - DW;

   logic [AW-1:0] disp_x;
   logic [AW-1:0] abs_x;
   logic [AW-1:0] step;
   logic [AW-1:0] idx_sc;

   assign disp_x = {{XW{disp[DW-1]}}, disp};

   if (ABS_SIGNED) begin : g_abs_s
      assign abs_x = disp_x;
   end else begin : g_abs_z
      assign abs_x = {{XW{1'b0}}, disp};
   end

   ea_scale #(.AW(AW), .SW(SW)) u_step (
      .val (AW'(1)),
      .sel (sel),
      .res (step)
   );

   ea_scale #(.AW(AW), .SW(SW)) u_idx (
      .val (index),
      .sel (sel),
      .res (idx_sc)
   );

   always_comb begin
      ea       = '0;
      wb       = '0;
      wb_en    = 1'b0;
      no_mem   = 1'b0;
      indirect = 1'b0;
      case (ea_mode_e'(mode))
         M_DISP: ea = disp_x + base;
         M_RIND: ea = base;
         M_IDX:  ea = base + index;
         M_ABS:  ea = abs_x;
         M_MIND: indirect = 1'b1;
         M_AINC: begin
            ea    = base;
            wb    = base + step;
            wb_en = 1'b1;
         end
         M_ADEC: begin
            ea    = base - step;
            wb    = base - step;
            wb_en = 1'b1;
         end
         M_SCL:  ea = disp_x + base + idx_sc;
         default: no_mem = 1'b1;
      endcase
   end
endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
   parameter int AW         = 32,
   parameter int DW         = 16,
   parameter int SW         = 2,
   parameter bit ABS_SIGNED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [3:0]    mode,
   input  logic [AW-1:0] base_val,
   input  logic [AW-1:0] index_val,
   input  logic [DW-1:0] disp,
   input  logic [SW-1:0] scale_sel,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic [AW-1:0] mem_rdata,
   output logic          done,
   output logic          no_mem,
   output logic [AW-1:0] ea_out,
   output logic          wb_en,
   output logic [AW-1:0] wb_val
);
   initial begin
      assert (DW > 0 && DW < AW) else $error("ea_unit: DW must be below AW");
      assert (SW > 0 && (1 << SW) <= AW) else $error("ea_unit: SW out of range");
   end

   logic          wait_q;
   logic          accept;
   logic [AW-1:0] c_ea;
   logic [AW-1:0] c_wb;
   logic          c_wb_en;
   logic          c_no_mem;
   logic          c_ind;

   ea_calc #(.AW(AW), .DW(DW), .SW(SW), .ABS_SIGNED(ABS_SIGNED)) u_calc (
      .mode     (mode),
      .base     (base_val),
      .index    (index_val),
      .disp     (disp),
      .sel      (scale_sel),
      .ea       (c_ea),
      .wb       (c_wb),
      .wb_en    (c_wb_en),
      .no_mem   (c_no_mem),
      .indirect (c_ind)
   );

   assign in_ready = !wait_q;
   assign accept   = in_valid && in_ready;
   assign mem_req  = accept && c_ind;
   assign mem_addr = base_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q <= 1'b0;
         done   <= 1'b0;
         no_mem <= 1'b0;
         ea_out <= '0;
         wb_en  <= 1'b0;
         wb_val <= '0;
      end else begin
         done  <= 1'b0;
         wb_en <= 1'b0;
         if (wait_q) begin
            wait_q <= 1'b0;
            done   <= 1'b1;
            ea_out <= mem_rdata;
            no_mem <= 1'b0;
         end else if (accept) begin
            if (c_ind) begin
               wait_q <= 1'b1;
            end else begin
               done   <= 1'b1;
               ea_out <= c_ea;
               no_mem <= c_no_mem;
               wb_en  <= c_wb_en;
               wb_val <= c_wb;
            end
         end
      end
   end
endmodule

// File: rtl/ea_chk.sv
module ea_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic          mem_req,
   input logic [AW-1:0] mem_rdata,
   input logic          done,
   input logic          no_mem,
   input logic [AW-1:0] ea_out,
   input logic          wb_en
);
   p_accept_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !mem_req) |=> done);

   p_read_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> (!in_ready && !done));

   p_read_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> ##1 (done && !no_mem && ea_out == $past(mem_rdata)));

   p_nomem_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && no_mem) |-> (ea_out == '0 && !wb_en));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && in_ready) |=> !done);

   p_wb_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done);
endmodule

bind ea_unit ea_chk #(.AW(AW)) u_ea_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .mem_req   (mem_req),
   .mem_rdata (mem_rdata),
   .done      (done),
   .no_mem    (no_mem),
   .ea_out    (ea_out),
   .wb_en     (wb_en)
);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  mode = '0;
   logic [31:0] base_val = '0;
   logic [31:0] index_val = '0;
   logic [15:0] disp = '0;
   logic [1:0]  scale_sel = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_rdata = '0;
   logic        done;
   logic        no_mem;
   logic [31:0] ea_out;
   logic        wb_en;
   logic [31:0] wb_val;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ea_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .mode(mode), .base_val(base_val), .index_val(index_val), .disp(disp),
      .scale_sel(scale_sel), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .done(done), .no_mem(no_mem), .ea_out(ea_out),
      .wb_en(wb_en), .wb_val(wb_val)
   );

   function automatic logic [31:0] memf(input logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
   endfunction

   always @(posedge clk) if (mem_req) mem_rdata <= memf(mem_addr);

   function automatic logic [31:0] x_ea(input logic [3:0] m, input logic [31:0] b,
                                        input logic [31:0] i, input logic [15:0] d,
                                        input logic [1:0] s);
      logic [31:0] sx;
      logic [31:0] stp;
      sx  = {{16{d[15]}}, d};
      stp = 32'd1 << s;
      case (m)
         4'd2: return sx + b;
         4'd3: return b;
         4'd4: return b + i;
         4'd5: return sx;
         4'd6: return memf(b);
         4'd7: return b;
         4'd8: return b - stp;
         4'd9: return sx + b + (i << s);
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] x_wb(input logic [3:0] m, input logic [31:0] b,
                                        input logic [1:0] s);
      if (m == 4'd7) return b + (32'd1 << s);
      return b - (32'd1 << s);
   endfunction

   function automatic string tag_of(input logic [3:0] m);
      case (m)
         4'd2, 4'd3, 4'd4: return "R2";
         4'd5: return "R3";
         4'd9: return "R4";
         4'd7: return "R5";
         4'd8: return "R6";
         4'd6: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] m, input logic [31:0] b, input logic [31:0] i,
                         input logic [15:0] d, input logic [1:0] s);
      string t;
      logic  isw;
      logic  nm;
      t   = tag_of(m);
      isw = (m == 4'd7) || (m == 4'd8);
      nm  = (m < 4'd2) || (m > 4'd9);
      mode = m; base_val = b; index_val = i; disp = d; scale_sel = s;
      in_valid = 1'b1;
      #1;
      chk("R9", "in_ready", 32'(in_ready), 32'd1);
      chk(t, "mem_req", 32'(mem_req), 32'(m == 4'd6));
      if (m == 4'd6) chk("R7", "mem_addr", mem_addr, b);
      @(negedge clk);
      if (m == 4'd6) begin
         in_valid = 1'b0;
         #1;
         chk("R7", "in_ready wait", 32'(in_ready), 32'd0);
         chk("R7", "done wait", 32'(done), 32'd0);
         @(negedge clk);
      end
      chk("R9", "done", 32'(done), 32'd1);
      chk(t, "ea_out", ea_out, x_ea(m, b, i, d, s));
      chk(t, "no_mem", 32'(no_mem), 32'(nm));
      chk("R10", "wb_en", 32'(wb_en), 32'(isw));
      if (isw) chk(t, "wb_val", wb_val, x_wb(m, b, s));
   endtask

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h1357);
      repeat (3) @(negedge clk);
      chk("R1", "done in reset", 32'(done), 32'd0);
      chk("R1", "wb_en in reset", 32'(wb_en), 32'd0);
      chk("R1", "mem_req in reset", 32'(mem_req), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ea_out after reset", ea_out, 32'd0);
      chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);
      chk("R1", "done after reset", 32'(done), 32'd0);
      // directed corner cases
      run_op(4'd2, 32'h0000_1000, 32'h0, 16'h8000, 2'd0);
      run_op(4'd3, 32'hDEAD_BEEF, 32'h0, 16'h0, 2'd0);
      run_op(4'd4, 32'hFFFF_FFFF, 32'h2, 16'h0, 2'd0);
      run_op(4'd5, 32'h0, 32'h0, 16'hFFFF, 2'd0);
      run_op(4'd5, 32'h0, 32'h0, 16'h7FFF, 2'd0);
      run_op(4'd9, 32'h100, 32'h11, 16'hFFF0, 2'd3);
      run_op(4'd7, 32'hFFFF_FFFC, 32'h0, 16'h0, 2'd2);
      run_op(4'd8, 32'h0, 32'h0, 16'h0, 2'd3);
      run_op(4'd6, 32'h1234_5678, 32'h0, 16'h0, 2'd0);
      run_op(4'd0, 32'h55, 32'h66, 16'h77, 2'd1);
      run_op(4'd1, 32'h55, 32'h66, 16'h77, 2'd1);
      run_op(4'd15, 32'h55, 32'h66, 16'h77, 2'd1);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R9", "done idle", 32'(done), 32'd0);
      chk("R10", "wb_en idle", 32'(wb_en), 32'd0);
      for (int n = 0; n < 400; n++) begin
         run_op(4'($urandom % 16), $urandom, $urandom, 16'($urandom), 2'($urandom % 4));
      end
      in_valid = 1'b0;
      @(negedge clk);
      chk("R9", "done after stream", 32'(done), 32'd0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule